// File: doc/BRIEF.md
# Key-Mask Multicast Router

This block steers multicast packets for one node of a two-dimensional hexagonal mesh. Every packet carries a 32-bit key and enters on one of several ports. Six of these ports are links to neighbouring nodes. The rest are local processing cores. A small table is loaded through a write port. Each table entry holds a key, a mask and a set of destination ports.

When a packet is accepted, its key is compared with every valid entry in parallel. An entry matches when the packet key, ANDed with the entry mask, equals the entry key. When several entries match, the lowest-numbered one is used. The packet is then copied to every port in that entry's destination set.

A packet that matches nothing takes the default route. If it arrived on a link, it continues straight on to the opposite link. If it came from a local core, there is no straight-on direction, so the packet is discarded and an error flag pulses. Table entries are therefore only needed where a route starts, turns or ends at a core.

The router holds one packet at a time. It keeps every selected output valid until that output has taken the packet. New input is refused until the whole fan-out is complete.

Top module: `mcast_router`

## Requirements
- R1: After reset, out_valid is all zero, drop_err is 0, in_ready is 1, and every table entry is invalid.
- R2: A valid entry e matches a packet when (in_key & mask[e]) == key[e]. Invalid entries never match.
- R3: An entry whose mask is all ones matches exactly one key value: its own.
- R4: On a hit, out_valid is driven with the destination set of the matching entry, starting in the cycle after acceptance, and out_key carries the packet key. Bit p of a destination set and of out_valid stands for port p. Ports 0 to 5 are links and ports 6 and above are local cores.
- R5: When several valid entries match, the entry with the lowest index alone decides the destinations.
- R6: A packet that misses and arrived on link i (0 to 5) leaves on link (i+3) mod 6 only.
- R7: A packet that misses and arrived on a core port (in_port of 6 or more) produces no output. drop_err is high for exactly the one cycle after acceptance.
- R8: Each out_valid bit stays high until out_ready for that bit is seen at a clock edge, and then clears on its own. out_key stays stable while any output is pending.
- R9: in_ready is low while any output is pending. The next packet is accepted only after every selected output has accepted the current one.
- R10: A write with tbl_we loads key, mask, destination set and valid flag into entry tbl_idx. A packet accepted in the same cycle as the write is routed with the old table contents. Writing tbl_valid = 0 removes the entry.
- R11: A hit on an entry whose destination set is empty consumes the packet with no output and no drop_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | $clog2(N_ENT) | Entry index to write |
| tbl_valid | input | 1 | Valid flag written to the entry |
| tbl_key | input | KEY_W | Entry key |
| tbl_mask | input | KEY_W | Entry mask |
| tbl_dest | input | 6+N_CORE | Entry destination set, one bit per port |
| in_valid | input | 1 | Input packet valid |
| in_ready | output | 1 | Router can take a packet |
| in_key | input | KEY_W | Packet routing key |
| in_port | input | $clog2(6+N_CORE) | Arrival port of the packet |
| out_valid | output | 6+N_CORE | Per-port output valid |
| out_ready | input | 6+N_CORE | Per-port output ready |
| out_key | output | KEY_W | Key of the packet being delivered |
| drop_err | output | 1 | One-cycle pulse when a core packet misses |

## Verification
An empty table is first driven with packets from all six links. This separates the mapping to the opposite link from any other rotation of the link numbers. Directed cases cover:
- exact-key entries against masked entries, which shows whether the mask is applied to the packet key;
- two overlapping entries, which shows which index wins;
- core-port misses against link misses;
- empty destination sets;
- a table write made in the same cycle as a packet is accepted.

Constrained random traffic is drawn near random table keys, so both hits and misses occur. Each output's ready is also random. Together these show whether every fan-out copy is delivered exactly once, and whether input is held off until all copies have gone.

// File: rtl/mcast_router.sv
`timescale 1ns/1ps
module mcast_router #(
  parameter int KEY_W  = 32,
  parameter int N_ENT  = 8,
  parameter int N_CORE = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  tbl_we,
  input  logic [$clog2(N_ENT)-1:0]              tbl_idx,
  input  logic                                  tbl_valid,
  input  logic [KEY_W-1:0]                      tbl_key,
  input  logic [KEY_W-1:0]                      tbl_mask,
  input  logic [6+N_CORE-1:0]                   tbl_dest,
  input  logic                                  in_valid,
  output logic                                  in_ready,
  input  logic [KEY_W-1:0]                      in_key,
  input  logic [$clog2(6+N_CORE)-1:0]           in_port,
  output logic [6+N_CORE-1:0]                   out_valid,
  input  logic [6+N_CORE-1:0]                   out_ready,
  output logic [KEY_W-1:0]                      out_key,
  output logic                                  drop_err
);
  localparam int N_LINK = 6;
  localparam int N_PORT = N_LINK + N_CORE;
  localparam int PW     = $clog2(N_PORT);
  localparam int HALF   = N_LINK / 2;

  logic [KEY_W-1:0]  ekey  [N_ENT];
  logic [KEY_W-1:0]  emask [N_ENT];
  logic [N_PORT-1:0] edest [N_ENT];
  logic [N_ENT-1:0]  evld;

  logic [N_PORT-1:0] pend;
  logic [KEY_W-1:0]  key_q;
  logic              err_q;

  logic              hit;
  logic [N_PORT-1:0] hit_dest;
  logic [N_PORT-1:0] dflt;
  logic              from_link;
  logic [PW-1:0]     opp;
  logic              accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evld <= '0;
    end else if (tbl_we) begin
      evld[tbl_idx] <= tbl_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (tbl_we) begin
      ekey[tbl_idx]  <= tbl_key;
      emask[tbl_idx] <= tbl_mask;
      edest[tbl_idx] <= tbl_dest;
    end
  end

  always_comb begin
    hit      = 1'b0;
    hit_dest = '0;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (evld[e] && ((in_key & emask[e]) == ekey[e])) begin
        hit      = 1'b1;
        hit_dest = edest[e];
      end
    end
  end

  assign from_link = in_port < PW'(N_LINK);
  assign opp       = (in_port >= PW'(HALF)) ? in_port - PW'(HALF) : in_port + PW'(HALF);

  always_comb begin
    dflt = '0;
    if (from_link) dflt[opp] = 1'b1;
  end

  assign in_ready  = (pend == '0);
  assign accept    = in_valid && in_ready;
  assign out_valid = pend;
  assign out_key   = key_q;
  assign drop_err  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      key_q <= '0;
      err_q <= 1'b0;
    end else if (accept) begin
      pend  <= hit ? hit_dest : dflt;
      key_q <= in_key;
      err_q <= !hit && !from_link;
    end else begin
      pend  <= pend & ~out_ready;
      err_q <= 1'b0;
    end
  end

  assert_hold_until_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_valid & ~out_ready)) |=>
      ((out_valid & $past(out_valid & ~out_ready)) == $past(out_valid & ~out_ready)));

  assert_key_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_valid & ~out_ready)) |=> $stable(out_key));

  assert_no_new_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_valid) |=> ((out_valid & ~$past(out_valid)) == '0));

  assert_single_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit && from_link) |=> ($countones(out_valid) == 1));

  assert_drop_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err |-> ($past(in_valid && in_ready) && out_valid == '0));

  assert_drop_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err |=> !drop_err);
endmodule

// File: tb/mcast_router_bench.sv
`timescale 1ns/1ps
module mcast_router_bench;
  localparam int KEY_W  = 32;
  localparam int N_ENT  = 8;
  localparam int N_CORE = 4;
  localparam int N_PORT = 6 + N_CORE;
  localparam int IW     = $clog2(N_ENT);
  localparam int PW     = $clog2(N_PORT);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_we = 1'b0;
  logic [IW-1:0] tbl_idx = '0;
  logic tbl_valid = 1'b0;
  logic [KEY_W-1:0] tbl_key = '0, tbl_mask = '0;
  logic [N_PORT-1:0] tbl_dest = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [KEY_W-1:0] in_key = '0;
  logic [PW-1:0] in_port = '0;
  logic [N_PORT-1:0] out_valid;
  logic [N_PORT-1:0] out_ready = '0;
  logic [KEY_W-1:0] out_key;
  logic drop_err;

  always #2.5 clk = ~clk;

  mcast_router #(.KEY_W(KEY_W), .N_ENT(N_ENT), .N_CORE(N_CORE)) u_mcast_router (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid),
    .tbl_key(tbl_key), .tbl_mask(tbl_mask), .tbl_dest(tbl_dest), .in_valid(in_valid),
    .in_ready(in_ready), .in_key(in_key), .in_port(in_port), .out_valid(out_valid),
    .out_ready(out_ready), .out_key(out_key), .drop_err(drop_err));

  int n_chk = 0;
  int n_err = 0;
  logic [KEY_W-1:0]  m_key  [N_ENT];
  logic [KEY_W-1:0]  m_mask [N_ENT];
  logic [N_PORT-1:0] m_dest [N_ENT];
  logic              m_vld  [N_ENT];

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [N_PORT:0] expect_route(logic [KEY_W-1:0] k, int port);
    for (int e = 0; e < N_ENT; e++)
      if (m_vld[e] && ((k & m_mask[e]) == m_key[e])) return {1'b0, m_dest[e]};
    if (port < 6) return {1'b0, N_PORT'(1) << ((port + 3) % 6)};
    return {1'b1, N_PORT'(0)};
  endfunction

  task automatic twrite(int idx, bit v, logic [KEY_W-1:0] k, logic [KEY_W-1:0] m, logic [N_PORT-1:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = IW'(idx); tbl_valid = v; tbl_key = k; tbl_mask = m; tbl_dest = d;
    @(negedge clk);
    tbl_we = 1'b0;
    m_vld[idx] = v; m_key[idx] = k; m_mask[idx] = m; m_dest[idx] = d;
  endtask

  task automatic send(logic [KEY_W-1:0] k, int port, string req);
    logic [N_PORT:0] ex;
    logic [N_PORT-1:0] del, cur, rdy;
    logic [31:0] r;
    ex = expect_route(k, port);
    @(negedge clk);
    chk(in_ready == 1'b1, "R9", "in_ready idle", 64'(in_ready), 64'd1);
    in_valid = 1'b1; in_key = k; in_port = PW'(port); out_ready = '0;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == ex[N_PORT-1:0], req, "dest set", 64'(out_valid), 64'(ex[N_PORT-1:0]));
    chk(drop_err == ex[N_PORT], "R7", "drop_err", 64'(drop_err), 64'(ex[N_PORT]));
    del = '0;
    while (out_valid != '0) begin
      cur = out_valid;
      chk(in_ready == 1'b0, "R9", "in_ready busy", 64'(in_ready), 64'd0);
      chk(out_key == k, "R4", "out_key", 64'(out_key), 64'(k));
      r = $urandom;
      rdy = r[N_PORT-1:0];
      out_ready = rdy;
      del |= cur & rdy;
      @(negedge clk);
      chk(out_valid == (cur & ~rdy), "R8", "pending after ready", 64'(out_valid), 64'(cur & ~rdy));
    end
    out_ready = '0;
    chk(del == ex[N_PORT-1:0], req, "delivered", 64'(del), 64'(ex[N_PORT-1:0]));
    if (ex[N_PORT-1:0] == '0) begin
      @(negedge clk);
      chk(drop_err == 1'b0, "R7", "drop pulse end", 64'(drop_err), 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int e = 0; e < N_ENT; e++) begin
      m_vld[e] = 1'b0; m_key[e] = '0; m_mask[e] = '0; m_dest[e] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == '0, "R1", "out_valid reset", 64'(out_valid), 64'd0);
    chk(drop_err == 1'b0, "R1", "drop_err reset", 64'(drop_err), 64'd0);
    chk(in_ready == 1'b1, "R1", "in_ready reset", 64'(in_ready), 64'd1);

    // R1/R6: empty table, every link goes straight on
    for (int p = 0; p < 6; p++) send(32'h0, p, "R6");

    // R10: write and packet in the same cycle use the old table
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = IW'(7); tbl_valid = 1'b1; tbl_key = 32'h55;
    tbl_mask = '1; tbl_dest = N_PORT'(1) << 8;
    in_valid = 1'b1; in_key = 32'h55; in_port = PW'(1);
    @(negedge clk);
    tbl_we = 1'b0; in_valid = 1'b0;
    chk(out_valid == N_PORT'(1 << 4), "R10", "same-cycle write", 64'(out_valid), 64'(1 << 4));
    out_ready = '1;
    @(negedge clk);
    out_ready = '0;
    m_vld[7] = 1'b1; m_key[7] = 32'h55; m_mask[7] = '1; m_dest[7] = N_PORT'(1) << 8;
    send(32'h55, 1, "R10");

    // R3: exact match, neighbouring keys miss
    send(32'h54, 1, "R3");
    send(32'h8000_0055, 2, "R3");

    // R2/R4: masked entry with mixed link and core fan-out
    twrite(3, 1'b1, 32'hA000_0000, 32'hF000_0000, N_PORT'(10'b11_0000_1001));
    send(32'hA123_4567, 0, "R2");
    send(32'hB123_4567, 0, "R2");
    // R5: overlap; entry 1 is lower than entry 3
    twrite(1, 1'b1, 32'hA100_0000, 32'hFF00_0000, N_PORT'(10'b00_0010_0000));
    send(32'hA1FF_0000, 4, "R5");
    send(32'hA2FF_0000, 4, "R5");
    // R7: core miss drops
    send(32'h1234_0000, 6, "R7");
    send(32'h1234_0000, N_PORT - 1, "R7");
    // R11: empty destination set
    twrite(0, 1'b1, 32'h0000_0F00, 32'h0000_FF00, '0);
    send(32'h0000_0F12, 3, "R11");
    // R10: clearing an entry
    twrite(0, 1'b0, 32'h0000_0F00, 32'h0000_FF00, '0);
    send(32'h0000_0F12, 3, "R10");

    // Random table and traffic
    for (int e = 0; e < N_ENT; e++) begin
      logic [KEY_W-1:0] mk, ky;
      mk = {24'hFF_FFFF, 8'($urandom)};
      ky = {24'($urandom % 4), 8'($urandom)} & mk;
      twrite(e, ($urandom % 5) != 0, ky, mk, N_PORT'($urandom));
    end
    for (int i = 0; i < 400; i++) begin
      int e, p;
      logic [KEY_W-1:0] k;
      e = int'($urandom % N_ENT);
      p = int'($urandom % N_PORT);
      if ($urandom % 4 == 0) k = {24'($urandom % 6), 8'($urandom)};
      else k = m_key[e] | ($urandom & ~m_mask[e]);
      send(k, p, "R4");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule